// File: doc/BRIEF.md
# Rollover-Aligned Serial Transmitter

This block is the transmit half of an asynchronous serial port. A write to its transmit buffer queues one frame. The frame carries a low start bit, eight data bits sent least significant bit first, an optional ninth bit taken from a separate input, and a high stop bit. The serial line rests high between frames.

All bit timing comes from a four-bit slice counter inside the block. The counter advances on every pulse of an external 16x tick and runs without pause. A buffer write never resets it, so bit edges follow the counter's rollovers rather than the moment of the write. The start bit appears at the first rollover after the write, and each later bit appears one rollover after the one before it. A sticky done flag rises on the rollover that puts the stop bit on the line. It stays high until a clear strobe arrives.

The surrounding port supplies the tick from its baud generator and handles any interrupt. The tick source and the interrupt logic are not part of this block.

Top module: `tick_uart_tx`

## Requirements
- R1: While reset is held and on leaving reset, `txd` is 1, `tx_done` is 0, and the slice counter is 0.
- R2: The slice counter advances by one on each cycle with `tick16` high, and only on those cycles. A rollover is the tick that takes the counter from 15 back to 0, so the first rollover is the 16th tick after reset. No write changes the counter, and `txd` does not change on a cycle without a rollover.
- R3: A write (`wr_en` high) to an idle transmitter is accepted. The start bit (0) appears on `txd` on the cycle after the first rollover that falls strictly after the write cycle. A rollover in the write cycle itself does not count.
- R4: Each later frame bit appears on the cycle after the next rollover, and it holds until the rollover after that. The data bits follow the start bit with `wr_data[0]` first.
- R5: When `nine_bit` is 1 at the write, the frame has 11 bits: start, 8 data bits, the captured `bit9_val`, then the stop bit (1).
- R6: When `nine_bit` is 0 at the write, the frame has 10 bits: start, 8 data bits, then the stop bit (1).
- R7: `tx_done` rises together with the stop bit, at the 11th rollover after the write in 9-bit mode and the 10th in 8-bit mode. It then stays 1 until a clear.
- R8: A write is ignored while a frame is in progress. That period runs from the cycle after the write is accepted through the rollover that ends the stop bit, inclusive. An ignored write changes neither the bits still to be sent nor starts a second frame.
- R9: `flag_clr` drops `tx_done` on the next cycle. When it arrives on the same cycle as the stop-bit rollover, the flag still ends up set.
- R10: The frame length and the ninth bit are taken from `nine_bit` and `bit9_val` in the write cycle. Later changes to those inputs do not alter the frame in flight.
- R11: The rollover after the stop-bit rollover ends the frame. From then on `txd` stays 1 and the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Data byte to send |
| bit9_val | input | 1 | Ninth bit value, used in 9-bit mode |
| nine_bit | input | 1 | Frame format: 1 = 11-bit frame, 0 = 10-bit frame |
| flag_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial output line |
| tx_done | output | 1 | Sticky transmit-complete flag |

## Verification
The bench issues writes at many counter phases and at several tick rates. A design that restarts its counter on a write would shift every bit edge and fail these checks. One write lands exactly on a rollover cycle, which exposes a design that counts that rollover as the first one and sends the start bit 16 ticks early. Extra writes arrive mid-frame, and the format and ninth-bit inputs are flipped mid-frame. These catch a design that reloads its buffer during a frame or reads those inputs live. The clear strobe is held across the stop-bit rollover, and the tick is paused inside a frame. A design that lets clear win over set, or that moves bits without a rollover, fails there.

// File: rtl/tick_uart_pkg.sv
package tick_uart_pkg;

    typedef enum logic {
        FMT_TEN    = 1'b0,
        FMT_ELEVEN = 1'b1
    } frame_fmt_e;

    // Number of bits on the line for one frame: start + data + optional ninth + stop
    function automatic int unsigned line_bits(input int unsigned data_w, input frame_fmt_e fmt);
        return data_w + 2 + ((fmt == FMT_ELEVEN) ? 1 : 0);
    endfunction

endpackage

// File: rtl/tuart_slice_div.sv
module tuart_slice_div #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic roll
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        roll = 1'b0;
        if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                roll     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tuart_shifter.sv
module tuart_shifter
    import tick_uart_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              roll,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              ninth,
    input  logic              fmt,
    output logic              txd,
    output logic              busy,
    output logic              stop_set
);
    localparam int unsigned FRAME_W = DATA_W + 3;
    localparam int unsigned CW      = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CW-1:0]      sent;
        logic [CW-1:0]      len;
        logic               busy;
        logic               txd;
    } sh_st_t;

    sh_st_t st_d, st_q;
    frame_fmt_e fmt_e;

    assign fmt_e = frame_fmt_e'(fmt);

    always_comb begin
        st_d     = st_q;
        stop_set = 1'b0;
        if (st_q.busy) begin
            if (roll) begin
                if (st_q.sent == st_q.len) begin
                    // stop bit period over: back to idle
                    st_d.busy = 1'b0;
                    st_d.txd  = 1'b1;
                end else begin
                    st_d.txd  = st_q.sh[0];
                    st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                    st_d.sent = st_q.sent + CW'(1);
                    stop_set  = ((st_q.sent + CW'(1)) == st_q.len);
                end
            end
        end else if (load) begin
            st_d.busy = 1'b1;
            st_d.sent = '0;
            st_d.len  = CW'(line_bits(DATA_W, fmt_e));
            st_d.sh   = {1'b1, (fmt_e == FMT_ELEVEN) ? ninth : 1'b1, data, 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.txd  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd  = st_q.txd;
    assign busy = st_q.busy;
endmodule

// File: rtl/tuart_flag.sv
module tuart_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } fl_st_t;

    fl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set)      st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/tick_uart_tx.sv
module tick_uart_tx #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit9_val,
    input  logic              nine_bit,
    input  logic              flag_clr,
    output logic              txd,
    output logic              tx_done
);
    logic roll_w;
    logic busy_w;
    logic stop_set_w;

    tuart_slice_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick16),
        .roll (roll_w)
    );

    tuart_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .roll    (roll_w),
        .load    (wr_en),
        .data    (wr_data),
        .ninth   (bit9_val),
        .fmt     (nine_bit),
        .txd     (txd),
        .busy    (busy_w),
        .stop_set(stop_set_w)
    );

    tuart_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (stop_set_w),
        .clr  (flag_clr),
        .flag (tx_done)
    );
endmodule

// File: rtl/tuart_tx_checker.sv
module tuart_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic flag_clr,
    input logic txd,
    input logic tx_done,
    input logic busy,
    input logic roll,
    input logic set_p
);
    // R1 / R11: an idle line is high
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2: rollovers only come from a tick
    assert_roll_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        roll |-> tick16);

    // R4: the line moves only after a rollover
    assert_txd_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> $stable(txd));

    // R7: flag is raised only by a rollover inside a frame, and the stop bit is on the line with it
    assert_set_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_p |-> (busy && roll));
    assert_set_with_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_p |=> (tx_done && txd));

    // R7: flag is sticky without a clear
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !flag_clr) |=> tx_done);

    // R9: clear without a set drops the flag
    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !set_p) |=> !tx_done);
endmodule

bind tick_uart_tx tuart_tx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick16  (tick16),
    .flag_clr(flag_clr),
    .txd     (txd),
    .tx_done (tx_done),
    .busy    (busy_w),
    .roll    (roll_w),
    .set_p   (stop_set_w)
);

// File: tb/sim_tick_uart_tx.sv
module sim_tick_uart_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit9_val = 1'b0;
    logic       nine_bit = 1'b0;
    logic       flag_clr = 1'b0;
    logic       txd;
    logic       tx_done;

    always #2 clk = ~clk;

    tick_uart_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .bit9_val(bit9_val), .nine_bit(nine_bit), .flag_clr(flag_clr),
        .txd(txd), .tx_done(tx_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_cyc = 0;

    // reference model state
    int         tc = 0;
    bit         mb = 0;
    int         mk = 0;
    logic [7:0] md = 8'h00;
    logic       mb9 = 1'b0;
    bit         m9 = 0;
    int         mlen = 10;
    logic       e_txd = 1'b1;
    logic       e_flag = 1'b0;
    string      ctx = "";

    // vectors: [11] nine_bit, [10] bit9, [9:2] data, [1:0] tick gap
    localparam logic [11:0] VEC [0:5] = '{
        {1'b1, 1'b1, 8'hA5, 2'd1},
        {1'b1, 1'b0, 8'h3C, 2'd2},
        {1'b0, 1'b0, 8'hFF, 2'd1},
        {1'b0, 1'b1, 8'h00, 2'd3},
        {1'b1, 1'b1, 8'h81, 2'd1},
        {1'b0, 1'b0, 8'h5A, 2'd2}
    };

    always @(posedge clk) begin
        n_cyc <= n_cyc + 1;
        if (n_cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic exp_bit(input int k);
        if (k == 1) return 1'b0;
        if (k >= 2 && k <= 9) return md[k-2];
        if (k == 10 && m9) return mb9;
        return 1'b1;
    endfunction

    function automatic string tag_for();
        if (!mb) return "R11";
        if (mk <= 1) return "R3";
        if (mk <= 9) return "R4";
        if (m9) return "R5";
        return "R6";
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        n_cmp = n_cmp + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic model(input logic t, input logic w, input logic [7:0] d,
                         input logic b, input logic m, input logic c);
        bit roll;
        bit set;
        bit nb;
        roll = t && (tc == 15);
        if (t) tc = (tc + 1) % 16;
        set = 0;
        nb  = mb;
        if (mb) begin
            if (roll) begin
                if (mk == mlen) begin
                    nb = 0;
                    e_txd = 1'b1;
                end else begin
                    mk = mk + 1;
                    e_txd = exp_bit(mk);
                    if (mk == mlen) set = 1;
                end
            end
        end else if (w) begin
            nb = 1; mk = 0; md = d; mb9 = b; m9 = m; mlen = m ? 11 : 10;
        end
        if (set) e_flag = 1'b1;
        else if (c) e_flag = 1'b0;
        mb = nb;
    endtask

    task automatic cyc(input logic t, input logic w, input logic [7:0] d,
                       input logic b, input logic m, input logic c);
        tick16 = t; wr_en = w; wr_data = d; bit9_val = b; nine_bit = m; flag_clr = c;
        @(posedge clk); #1;
        model(t, w, d, b, m, c);
        chk(txd, e_txd, (ctx.len() > 0) ? ctx : tag_for(), "txd");
        chk(tx_done, e_flag, (ctx.len() > 0) ? ctx : "R7", "tx_done");
    endtask

    // finish the frame in flight; format/ninth inputs flipped (R10) and stray writes (R8)
    task automatic drive_frame(input int gap, input bit hold_clr);
        int n = 0;
        while (mb && n < 2000) begin
            cyc(((n % gap) == 0), ((n % 37) == 5), ~md, ~mb9, ~m9, hold_clr);
            n++;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(posedge clk);
        #1;
        chk(txd, 1'b1, "R1", "txd in reset");
        chk(tx_done, 1'b0, "R1", "tx_done in reset");
        rst_n = 1'b1;
        cyc(0, 0, 8'h00, 0, 0, 0);
        chk(txd, 1'b1, "R1", "txd after reset");

        // table walk
        for (int i = 0; i < 6; i++) begin
            int gap;
            gap = int'(VEC[i][1:0]);
            for (int j = 0; j < 3 + 5 * i; j++) cyc(((j % gap) == 0), 0, 8'h00, 0, 0, 0);
            cyc(1, 1, VEC[i][9:2], VEC[i][10], VEC[i][11], 0);
            drive_frame(gap, 0);
            chk(tx_done, 1'b1, VEC[i][11] ? "R5" : "R6", "flag after frame");
            for (int j = 0; j < 20; j++) cyc(1, 0, 8'h00, 0, 0, 0);
            chk(tx_done, 1'b1, "R7", "flag sticky");
            chk(txd, 1'b1, "R11", "idle after frame");
            cyc(0, 0, 8'h00, 0, 0, 1);
            chk(tx_done, 1'b0, "R9", "flag cleared");
        end

        // R3: write on a rollover cycle, that rollover is not counted
        while (tc != 15) cyc(1, 0, 8'h00, 0, 0, 0);
        cyc(1, 1, 8'h96, 1, 1, 0);
        chk(txd, 1'b1, "R3", "no start at write-cycle rollover");
        for (int j = 0; j < 15; j++) cyc(1, 0, 8'h00, 0, 0, 0);
        chk(txd, 1'b1, "R3", "still idle before first rollover");
        cyc(1, 0, 8'h00, 0, 0, 0);
        chk(txd, 1'b0, "R3", "start bit at first later rollover");
        drive_frame(1, 0);
        cyc(0, 0, 8'h00, 0, 0, 1);

        // R2: paused tick freezes the line mid-frame; write phase off a rollover
        for (int j = 0; j < 7; j++) cyc(1, 0, 8'h00, 0, 0, 0);
        cyc(1, 1, 8'hC3, 0, 1, 0);
        while (mb && mk < 3) cyc(1, 0, 8'h00, 0, 0, 0);
        ctx = "R2";
        for (int j = 0; j < 40; j++) cyc(0, 0, 8'h00, 0, 0, 0);
        ctx = "";
        drive_frame(1, 0);
        cyc(0, 0, 8'h00, 0, 0, 1);

        // R8: back-to-back write attempts every cycle of a frame
        cyc(1, 1, 8'h0F, 0, 0, 0);
        ctx = "R8";
        while (mb) cyc(1, 1, 8'hF0, 1, 1, 0);
        ctx = "";
        for (int j = 0; j < 40; j++) cyc(1, 0, 8'h00, 0, 0, 0);
        chk(txd, 1'b1, "R8", "no second frame from ignored writes");
        cyc(0, 0, 8'h00, 0, 0, 1);

        // R9: clear held across the stop-bit rollover, set wins
        cyc(1, 1, 8'h33, 1, 1, 0);
        ctx = "R9";
        while (mb && mk < 11) cyc(1, 0, 8'h00, 0, 0, 1);
        chk(tx_done, 1'b1, "R9", "set beats clear");
        cyc(0, 0, 8'h00, 0, 0, 1);
        chk(tx_done, 1'b0, "R9", "clear after collision");
        ctx = "";
        drive_frame(1, 0);

        // R11: new write accepted right after a frame ends
        cyc(1, 1, 8'h66, 0, 0, 0);
        drive_frame(1, 0);
        chk(tx_done, 1'b1, "R11", "second frame completed");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule